// File: doc/BRIEF.md
# Branch Target Buffer with Per-Entry History

This block sits beside the instruction cache in the fetch stage. Each cycle it compares the fetch address with every stored branch address at once. On a match it returns the stored target and that entry's history bits. A direction rule turns the history bits into a taken or not-taken choice. When the choice is taken, the stored target becomes the next fetch address. Otherwise the next fetch address is the fall-through address, which is the fetch address plus the instruction size.

A second port carries resolved branches back from the execute stage. A resolved branch with no entry gets a new one. The block uses the lowest free slot, or a round-robin victim when every slot is valid. A resolved branch that already has an entry updates its history, and its target when the branch was taken. In the same cycle the port compares the resolved direction and target with what was speculated at fetch and reports any difference as a misprediction.

Top module: `btbh_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every entry and sets the replacement pointer to entry 0. After reset every lookup misses, with `pred_hit`=0, `pred_taken`=0, `pred_target`=0 and `pred_hist`=0.
- R2: When `fetch_pc` equals the stored address of a valid entry, `pred_hit` is 1 and `pred_target`/`pred_hist` show that entry's target and history in the same cycle. On a miss both read 0.
- R3: History bit 0 is the most recent outcome, and 1 means taken. `pred_taken` is 1 exactly when there is a hit and at least one history bit is 1.
- R4: `next_pc` equals `pred_target` when `pred_taken` is 1. Otherwise it equals `fetch_pc + INSN_BYTES`.
- R5: A resolution (`res_valid`=1) whose `res_pc` matches no valid entry allocates one. The entry gets tag `res_pc`, target `res_target`, and a history of all zeros except bit 0, which is `res_taken`.
- R6: A resolution that matches a valid entry shifts that entry's history left by one. `res_taken` enters at bit 0 and the oldest bit is dropped. The target is replaced by `res_target` only when `res_taken` is 1.
- R7: `mispredict` is 1 in the same cycle when `res_valid` is 1 and either `res_taken` differs from `res_pred_taken`, or both are taken and `res_target` differs from `res_pred_target`. Otherwise it is 0.
- R8: Allocation uses the lowest-numbered invalid entry. When all entries are valid, it replaces the entry at the round-robin pointer, and the pointer then advances by one, wrapping from the last entry to entry 0.
- R9: At most one valid entry ever holds a given branch address. Resolving a branch that is already present never allocates and never moves the pointer.
- R10: A lookup in the same cycle as an update sees the contents from before the update. The update is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | AW | Current fetch address |
| pred_hit | output | 1 | A valid entry matches `fetch_pc` |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | AW | Stored target of the matching entry, 0 on a miss |
| pred_hist | output | HB | History bits of the matching entry, 0 on a miss |
| next_pc | output | AW | Next fetch address |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | AW | Address of the resolved branch |
| res_taken | input | 1 | Resolved direction |
| res_target | input | AW | Resolved target |
| res_pred_taken | input | 1 | Direction that was speculated at fetch |
| res_pred_target | input | AW | Target that was speculated at fetch |
| mispredict | output | 1 | Resolved outcome disagrees with the speculation |

## Verification
A corrupted tag, valid bit or history field shows up at the fetch ports on the first lookup of that address after the fault. It appears as a wrong `pred_hit`, `pred_hist` or `next_pc`. A misplaced allocation or a pointer that drifts stays hidden until the buffer fills. It then shows up as the wrong address being evicted, which is seen on the next lookup of the survivor or of the victim. The bench therefore fills the buffer past capacity, and drives lookups to addresses that are resolving in the same cycle to expose update-timing faults at once.

// File: rtl/btbh_pkg.sv
package btbh_pkg;

    // Kind of state change a resolution causes in a given cycle.
    typedef enum logic [1:0] {
        ACT_IDLE        = 2'd0,
        ACT_REFRESH     = 2'd1,
        ACT_ALLOC_FREE  = 2'd2,
        ACT_ALLOC_EVICT = 2'd3
    } upd_act_e;

endpackage

// File: rtl/btbh_cam.sv
// Fully associative compare of one key against all stored branch addresses.
module btbh_cam #(
    parameter int N  = 16,
    parameter int AW = 32,
    parameter int IW = 4
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic [N-1:0]         match,
    output logic                 hit,
    output logic [IW-1:0]        idx
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign match[g] = valid[g] && (tags[g] == key);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/btbh_dir.sv
// Direction rule: taken when any tracked outcome was taken.
module btbh_dir #(
    parameter int HB = 2
) (
    input  logic [HB-1:0] hist,
    output logic          taken
);
    assign taken = |hist;
endmodule

// File: rtl/btbh_victim.sv
// Chooses the entry that receives a new allocation.
module btbh_victim #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  valid,
    input  logic [IW-1:0] rr,
    output logic [IW-1:0] victim,
    output logic          full
);
    logic found;

    always_comb begin
        full   = &valid;
        victim = rr;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found) begin
                victim = IW'(i);
                found  = 1'b1;
            end
        end
    end

    AST_FREE_SLOT_FIRST: assert property (@(posedge clk) disable iff (rst)
        !full |-> !valid[victim]); // R8
    AST_FULL_USES_POINTER: assert property (@(posedge clk) disable iff (rst)
        full |-> victim == rr); // R8
endmodule

// File: rtl/btbh_top.sv
module btbh_top #(
    parameter int N          = 16,
    parameter int AW         = 32,
    parameter int HB         = 2,
    parameter int INSN_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] fetch_pc,
    output logic          pred_hit,
    output logic          pred_taken,
    output logic [AW-1:0] pred_target,
    output logic [HB-1:0] pred_hist,
    output logic [AW-1:0] next_pc,
    input  logic          res_valid,
    input  logic [AW-1:0] res_pc,
    input  logic          res_taken,
    input  logic [AW-1:0] res_target,
    input  logic          res_pred_taken,
    input  logic [AW-1:0] res_pred_target,
    output logic          mispredict
);
    import btbh_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);
    localparam logic [AW-1:0] STEP     = AW'(INSN_BYTES);

    typedef struct packed {
        logic [N-1:0]         valid;
        logic [N-1:0][AW-1:0] tag;
        logic [N-1:0][AW-1:0] tgt;
        logic [N-1:0][HB-1:0] hist;
        logic [IW-1:0]        rr;
    } state_t;

    state_t   st_q, st_d;
    upd_act_e act_d;

    // Fetch-side lookup
    logic [N-1:0]  f_match;
    logic          f_hit;
    logic [IW-1:0] f_idx;
    logic          f_dir;

    btbh_cam #(.N(N), .AW(AW), .IW(IW)) u_cam_fetch (
        .valid (st_q.valid),
        .tags  (st_q.tag),
        .key   (fetch_pc),
        .match (f_match),
        .hit   (f_hit),
        .idx   (f_idx)
    );

    btbh_dir #(.HB(HB)) u_dir (
        .hist  (st_q.hist[f_idx]),
        .taken (f_dir)
    );

    // Resolution-side lookup
    logic [N-1:0]  r_match;
    logic          r_hit;
    logic [IW-1:0] r_idx;
    logic [IW-1:0] victim;
    logic          full;
    logic [IW-1:0] wr_idx;

    btbh_cam #(.N(N), .AW(AW), .IW(IW)) u_cam_res (
        .valid (st_q.valid),
        .tags  (st_q.tag),
        .key   (res_pc),
        .match (r_match),
        .hit   (r_hit),
        .idx   (r_idx)
    );

    btbh_victim #(.N(N), .IW(IW)) u_victim (
        .clk    (clk),
        .rst    (rst),
        .valid  (st_q.valid),
        .rr     (st_q.rr),
        .victim (victim),
        .full   (full)
    );

    // Prediction outputs
    always_comb begin
        pred_hit    = f_hit;
        pred_taken  = f_hit && f_dir;
        pred_target = f_hit ? st_q.tgt[f_idx]  : '0;
        pred_hist   = f_hit ? st_q.hist[f_idx] : '0;
        next_pc     = pred_taken ? st_q.tgt[f_idx] : (fetch_pc + STEP);
    end

    // Misprediction compare
    always_comb begin
        mispredict = res_valid &&
                     ((res_taken != res_pred_taken) ||
                      (res_taken && (res_target != res_pred_target)));
    end

    // Next-state computation
    always_comb begin
        st_d   = st_q;
        act_d  = ACT_IDLE;
        wr_idx = r_hit ? r_idx : victim;
        if (res_valid) begin
            if (r_hit) begin
                act_d = ACT_REFRESH;
                st_d.hist[r_idx] = HB'({st_q.hist[r_idx], res_taken});
                if (res_taken) st_d.tgt[r_idx] = res_target;
            end else begin
                act_d = full ? ACT_ALLOC_EVICT : ACT_ALLOC_FREE;
                st_d.valid[victim] = 1'b1;
                st_d.tag[victim]   = res_pc;
                st_d.tgt[victim]   = res_target;
                st_d.hist[victim]  = HB'(res_taken);
                if (full) begin
                    st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + IW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (rst)
        $onehot0(f_match)); // R9
    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> pred_hit); // R3
    AST_MISS_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (next_pc == fetch_pc + STEP) && !pred_taken); // R4
    AST_ALLOC_LANDS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !r_hit) |=> st_q.valid[$past(wr_idx)] &&
                                  (st_q.tag[$past(wr_idx)] == $past(res_pc))); // R5
    AST_REFRESH_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (res_valid && r_hit) |=> $stable(st_q.rr) && $stable(st_q.valid)); // R9
    AST_PTR_ONLY_ON_EVICT: assert property (@(posedge clk) disable iff (rst)
        (act_d != ACT_ALLOC_EVICT) |=> $stable(st_q.rr)); // R8
endmodule

// File: tb/btbh_top_tb.sv
module btbh_top_tb;
    localparam int N  = 16;
    localparam int AW = 32;
    localparam int HB = 2;
    localparam int IB = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] fetch_pc;
    logic          pred_hit, pred_taken;
    logic [AW-1:0] pred_target, next_pc;
    logic [HB-1:0] pred_hist;
    logic          res_valid, res_taken, res_pred_taken;
    logic [AW-1:0] res_pc, res_target, res_pred_target;
    logic          mispredict;

    always #5 clk = ~clk;

    btbh_top #(.N(N), .AW(AW), .HB(HB), .INSN_BYTES(IB)) u_dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_target(pred_target),
        .pred_hist(pred_hist), .next_pc(next_pc),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_pred_taken(res_pred_taken),
        .res_pred_target(res_pred_target), .mispredict(mispredict)
    );

    // Behavioural reference
    bit            m_valid [N];
    logic [AW-1:0] m_tag   [N];
    logic [AW-1:0] m_tgt   [N];
    int            m_hist  [N];
    int            m_rr;
    int vectors = 0;
    int fails   = 0;

    function automatic int m_find(logic [AW-1:0] pc);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    task automatic cmp(string tag, string req, string name, logic [AW-1:0] act, logic [AW-1:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s) %s: actual %h expected %h", tag, req, name, act, exp);
        end
    endtask

    task automatic m_clear();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_hist[i] = 0;
        end
        m_rr = 0;
    endtask

    task automatic step(string tag, logic [AW-1:0] fpc, logic rv, logic [AW-1:0] rpc,
                        logic rt, logic [AW-1:0] rtg, logic rpt, logic [AW-1:0] rptg);
        int k, f;
        logic e_hit, e_tk, e_mp;
        logic [AW-1:0] e_tgt, e_np;
        int e_hist;
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt;
        res_target = rtg; res_pred_taken = rpt; res_pred_target = rptg;
        #1;
        k      = m_find(fpc);
        e_hit  = (k >= 0);
        e_tgt  = e_hit ? m_tgt[k] : '0;
        e_hist = e_hit ? m_hist[k] : 0;
        e_tk   = e_hit && (e_hist != 0);
        e_np   = e_tk ? e_tgt : fpc + AW'(IB);
        e_mp   = rv && ((rt != rpt) || (rt && rtg != rptg));
        vectors++;
        cmp(tag, "R2", "pred_hit",    AW'(pred_hit),    AW'(e_hit));
        cmp(tag, "R2", "pred_target", pred_target,      e_tgt);
        cmp(tag, "R2", "pred_hist",   AW'(pred_hist),   AW'(e_hist));
        cmp(tag, "R3", "pred_taken",  AW'(pred_taken),  AW'(e_tk));
        cmp(tag, "R4", "next_pc",     next_pc,          e_np);
        cmp(tag, "R7", "mispredict",  AW'(mispredict),  AW'(e_mp));
        @(posedge clk);
        if (rv) begin
            k = m_find(rpc);
            if (k >= 0) begin                          // R6 refresh
                m_hist[k] = ((m_hist[k] << 1) | int'(rt)) & ((1 << HB) - 1);
                if (rt) m_tgt[k] = rtg;
            end else begin                             // R5, R8 allocate
                f = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) f = i;
                if (f < 0) begin f = m_rr; m_rr = (m_rr + 1) % N; end
                m_valid[f] = 1; m_tag[f] = rpc; m_tgt[f] = rtg; m_hist[f] = int'(rt);
            end
        end
    endtask

    task automatic look(string tag, logic [AW-1:0] fpc);
        step(tag, fpc, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic resolve(string tag, logic [AW-1:0] fpc, logic [AW-1:0] rpc, logic rt,
                           logic [AW-1:0] rtg, logic rpt, logic [AW-1:0] rptg);
        step(tag, fpc, 1'b1, rpc, rt, rtg, rpt, rptg);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; res_valid = 1'b0; fetch_pc = '0;
        repeat (2) @(posedge clk);
        m_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1) run: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; fetch_pc = '0; res_valid = 0; res_pc = '0; res_taken = 0;
        res_target = '0; res_pred_taken = 0; res_pred_target = '0;
        m_clear();
        do_reset();

        // R1: every lookup misses after reset
        look("R1", 32'h0000_0100);
        look("R1", 32'h0000_0000);
        look("R1", 32'hFFFF_FFFC);

        // R10 and R5: allocation not visible in its own cycle
        resolve("R10", 32'h100, 32'h100, 1'b1, 32'h80, 1'b0, 32'h0);
        look("R5", 32'h100);
        // R6: history shifts, target kept when not taken
        resolve("R6", 32'h100, 32'h100, 1'b0, 32'h44, 1'b1, 32'h80);
        resolve("R6", 32'h100, 32'h100, 1'b0, 32'h48, 1'b1, 32'h80);
        resolve("R6", 32'h100, 32'h100, 1'b1, 32'h90, 1'b0, 32'h104);
        resolve("R6", 32'h100, 32'h100, 1'b0, 32'h4C, 1'b1, 32'h90);
        look("R6", 32'h100);
        // R3: not-taken allocation hits but predicts fall-through
        resolve("R3", 32'h200, 32'h200, 1'b0, 32'h204, 1'b0, 32'h204);
        look("R3", 32'h200);
        // R7: target mismatch while both taken, and agreement
        resolve("R7", 32'h300, 32'h100, 1'b1, 32'h90, 1'b1, 32'h94);
        resolve("R7", 32'h300, 32'h100, 1'b1, 32'h90, 1'b1, 32'h90);
        resolve("R7", 32'h300, 32'h100, 1'b0, 32'h90, 1'b0, 32'h70);

        // R8: fill, then round-robin eviction
        do_reset();
        for (int i = 0; i < N; i++)
            resolve("R8", 32'h4000 + 32'(4 * i), 32'h4000 + 32'(4 * i), 1'b1,
                    32'h8000 + 32'(4 * i), 1'b0, 32'h0);
        look("R8", 32'h4000);
        resolve("R8", 32'h4000, 32'h5000, 1'b1, 32'h9000, 1'b0, 32'h0);
        look("R8", 32'h4000);
        look("R8", 32'h5000);
        // R9: existing branch while full refreshes, no eviction
        resolve("R9", 32'h4004, 32'h4008, 1'b0, 32'h0, 1'b1, 32'h8008);
        look("R9", 32'h4004);
        look("R9", 32'h4008);
        resolve("R8", 32'h4004, 32'h5004, 1'b1, 32'h9004, 1'b0, 32'h0);
        look("R8", 32'h4004);
        look("R8", 32'h4008);

        // Mixed traffic over a pool larger than the buffer
        for (int c = 0; c < 3000; c++) begin
            logic [AW-1:0] fp, rp, rtg, rptg;
            fp   = 32'h1000 + 32'(4 * ($urandom % 24));
            rp   = ($urandom % 3 == 0) ? fp : 32'h1000 + 32'(4 * ($urandom % 24));
            rtg  = 32'h2000 + 32'(4 * ($urandom % 8));
            rptg = ($urandom % 2 == 0) ? rtg : 32'h2000 + 32'(4 * ($urandom % 8));
            step("R6", fp, 1'($urandom % 4 != 0), rp, 1'($urandom), rtg, 1'($urandom), rptg);
        end

        // R1: reset in the middle of use
        do_reset();
        look("R1", 32'h1000);
        look("R1", 32'h5000);

        finish_run();
    end
endmodule